// File: doc/BRIEF.md
# Sampled Phase-Frequency Detector with Polarity Select

This block compares two divided clocks inside a fast system clock domain: a reference stream (`ref_i`) and a divided oscillator stream (`div_i`). Both arrive as level signals. They are resynchronised and reduced to rising-edge strobes. A rising edge on the reference sets an internal "advance" flag. A rising edge on the divided oscillator sets an internal "retard" flag. When both flags are set, a delayed clear path resets them together one cycle later. Only leading edges count, so the detector covers a full ±2π window and also acts as a frequency detector.

The two flags drive a pair of registered detector outputs, `phi_p_o` and `phi_r_o`. `phi_p_o` rests high and pulses low. `phi_r_o` rests low and pulses high. The polarity input `pol_i` selects which flag drives which output, so the same loop can serve an oscillator whose frequency rises with its control voltage and one whose frequency falls. `lock_o` is high while neither flag is set. `mon_o` is a test output that echoes one of the two synchronised inputs, also chosen by `pol_i`.

Top module: `pfd_phase_det`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first input edge, `phi_p_o`=1, `phi_r_o`=0, `lock_o`=1 and `mon_o`=0.
- R2: Only a 0→1 transition of `ref_i` or `div_i` sets its flag. A 1→0 transition does nothing. A further rising edge on an input whose flag is already set does not change the outputs.
- R3: With `pol_i`=1 and a `ref_i` edge that is not yet matched by a `div_i` edge, `phi_p_o`=0 and `phi_r_o`=0.
- R4: With `pol_i`=1 and a `div_i` edge that is not yet matched by a `ref_i` edge, `phi_r_o`=1 and `phi_p_o`=1.
- R5: With `pol_i`=0 and an unmatched `div_i` edge, `phi_p_o`=0 and `phi_r_o`=0.
- R6: With `pol_i`=0 and an unmatched `ref_i` edge, `phi_r_o`=1 and `phi_p_o`=1.
- R7: Once both flags are set, both stay set for exactly two cycles and are then cleared together. The outputs show `phi_p_o`=0 and `phi_r_o`=1 for those two cycles and return to idle (1/0) in the next cycle. This holds for coincident edges too.
- R8: `lock_o` is the NOR of the two flags. It is high at rest and low whenever either flag is set.
- R9: `mon_o` follows the synchronised `ref_i` when `pol_i`=1 and the synchronised `div_i` when `pol_i`=0. It lags the input by SYNC_STAGES+1 cycles. A change of `pol_i` shows on `mon_o` and on the detector outputs one cycle later.
- R10: A flag-setting input edge applied before clock edge k shows on `phi_p_o`, `phi_r_o` and `lock_o` after edge k+SYNC_STAGES+1, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than both compared streams |
| rst_ni | input | 1 | Active-low synchronous reset |
| ref_i | input | 1 | Divided reference stream (level) |
| div_i | input | 1 | Divided oscillator stream (level) |
| pol_i | input | 1 | Polarity / monitor select; 1 is the default sense |
| phi_p_o | output | 1 | Detector output, rests high, pulses low |
| phi_r_o | output | 1 | Detector output, rests low, pulses high |
| lock_o | output | 1 | High while neither flag is set |
| mon_o | output | 1 | Test echo of the selected synchronised input |

## Verification
The bench builds the block with the default SYNC_STAGES=2 and derives every expected cycle from that value: four cycles from an input change to the detector outputs, three to the monitor. The depth is shallow, so one short run covers all four lead/lag and polarity combinations, the two-cycle overlap before the joint clear, coincident edges, falling and repeated edges, and a polarity flip observed on the monitor path.

// File: rtl/pfd_pkg.sv
`timescale 1ns/1ps
package pfd_pkg;

    typedef enum logic {
        POL_SWAPPED = 1'b0,
        POL_DIRECT  = 1'b1
    } pol_e;

    typedef struct packed {
        logic adv;
        logic ret;
        logic clr;
    } core_st_t;

    typedef struct packed {
        logic phi_p;
        logic phi_r;
        logic lock;
        logic mon;
    } out_st_t;

    localparam core_st_t CORE_RST = '{adv: 1'b0, ret: 1'b0, clr: 1'b0};
    localparam out_st_t  OUT_RST  = '{phi_p: 1'b1, phi_r: 1'b0, lock: 1'b1, mon: 1'b0};

endpackage

// File: rtl/pfd_edge_in.sv
`timescale 1ns/1ps
module pfd_edge_in #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sig_i,
    output logic level_o,
    output logic rise_o
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = sig_i;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        st_d.prev = st_q.sync[LAST];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.sync[LAST];
    assign rise_o  = st_q.sync[LAST] & ~st_q.prev;

endmodule

// File: rtl/pfd_core.sv
`timescale 1ns/1ps
module pfd_core
    import pfd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref_rise_i,
    input  logic div_rise_i,
    output logic adv_o,
    output logic ret_o
);
    core_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // joint clear is armed one cycle after both flags are seen set
        st_d.clr = st_q.adv & st_q.ret & ~st_q.clr;
        if (st_q.clr) begin
            st_d.adv = ref_rise_i;
            st_d.ret = div_rise_i;
        end else begin
            st_d.adv = st_q.adv | ref_rise_i;
            st_d.ret = st_q.ret | div_rise_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= CORE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign adv_o = st_q.adv;
    assign ret_o = st_q.ret;

endmodule

// File: rtl/pfd_out.sv
`timescale 1ns/1ps
module pfd_out
    import pfd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pol_i,
    input  logic adv_i,
    input  logic ret_i,
    input  logic ref_lvl_i,
    input  logic div_lvl_i,
    output logic phi_p_o,
    output logic phi_r_o,
    output logic lock_o,
    output logic mon_o
);
    out_st_t st_d, st_q;
    pol_e    pol;

    assign pol = pol_e'(pol_i);

    always_comb begin
        st_d      = st_q;
        st_d.lock = ~(adv_i | ret_i);
        unique case (pol)
            POL_DIRECT: begin
                st_d.phi_p = ~adv_i;
                st_d.phi_r = ret_i;
                st_d.mon   = ref_lvl_i;
            end
            POL_SWAPPED: begin
                st_d.phi_p = ~ret_i;
                st_d.phi_r = adv_i;
                st_d.mon   = div_lvl_i;
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= OUT_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign phi_p_o = st_q.phi_p;
    assign phi_r_o = st_q.phi_r;
    assign lock_o  = st_q.lock;
    assign mon_o   = st_q.mon;

endmodule

// File: rtl/pfd_phase_det.sv
`timescale 1ns/1ps
module pfd_phase_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref_i,
    input  logic div_i,
    input  logic pol_i,
    output logic phi_p_o,
    output logic phi_r_o,
    output logic lock_o,
    output logic mon_o
);
    localparam int NUM_IN = 2;

    logic [NUM_IN-1:0] raw_w;
    logic [NUM_IN-1:0] lvl_w;
    logic [NUM_IN-1:0] rise_w;
    logic              adv_w;
    logic              ret_w;

    assign raw_w = {div_i, ref_i};

    for (genvar g = 0; g < NUM_IN; g++) begin : g_in
        pfd_edge_in #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .sig_i  (raw_w[g]),
            .level_o(lvl_w[g]),
            .rise_o (rise_w[g])
        );
    end

    pfd_core i_core (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ref_rise_i(rise_w[0]),
        .div_rise_i(rise_w[1]),
        .adv_o     (adv_w),
        .ret_o     (ret_w)
    );

    pfd_out i_out (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .pol_i    (pol_i),
        .adv_i    (adv_w),
        .ret_i    (ret_w),
        .ref_lvl_i(lvl_w[0]),
        .div_lvl_i(lvl_w[1]),
        .phi_p_o  (phi_p_o),
        .phi_r_o  (phi_r_o),
        .lock_o   (lock_o),
        .mon_o    (mon_o)
    );

endmodule

// File: rtl/pfd_phase_det_chk.sv
`timescale 1ns/1ps
module pfd_phase_det_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic pol_i,
    input logic adv_i,
    input logic ret_i,
    input logic ref_rise_i,
    input logic div_rise_i,
    input logic phi_p_i,
    input logic phi_r_i,
    input logic lock_i
);
    assert_lock_nor_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock_i == (phi_p_i && !phi_r_i));

    assert_idle_outputs_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!adv_i && !ret_i) |=> (phi_p_i && !phi_r_i && lock_i));

    assert_direct_advance_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && !ret_i && pol_i) |=> (!phi_p_i && !phi_r_i));

    assert_swapped_retard_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ret_i && !adv_i && !pol_i) |=> (!phi_p_i && !phi_r_i));

    assert_joint_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && ret_i && $past(adv_i && ret_i))
        |=> ((!adv_i || $past(ref_rise_i)) && (!ret_i || $past(div_rise_i))));

endmodule

bind pfd_phase_det pfd_phase_det_chk i_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pol_i     (pol_i),
    .adv_i     (adv_w),
    .ret_i     (ret_w),
    .ref_rise_i(rise_w[0]),
    .div_rise_i(rise_w[1]),
    .phi_p_i   (phi_p_o),
    .phi_r_i   (phi_r_o),
    .lock_i    (lock_o)
);

// File: tb/test_pfd_phase_det.sv
`timescale 1ns/1ps
module test_pfd_phase_det;
    localparam int SYNC = 2;
    localparam int LAT  = SYNC + 2;   // R10
    localparam int MLAT = SYNC + 1;   // R9
    localparam int WATCHDOG = 20000;

    typedef struct {
        int    cyc;
        bit    is_mon;
        logic  p, r, l, m;
        string tag;
    } exp_t;

    logic clk = 0, rst_n = 0, ref_s = 0, div_s = 0, pol = 1;
    logic phi_p, phi_r, lock, mon;
    int   cyc = 0, n_run = 0, n_fail = 0;
    bit   done = 0;
    exp_t sb[$];

    pfd_phase_det #(.SYNC_STAGES(SYNC)) i_pfd_phase_det (
        .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_s), .div_i(div_s), .pol_i(pol),
        .phi_p_o(phi_p), .phi_r_o(phi_r), .lock_o(lock), .mon_o(mon));

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic at(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic exp_pfd(input int c, input logic p, r, l, input string tag);
        sb.push_back('{cyc: c, is_mon: 0, p: p, r: r, l: l, m: 1'b0, tag: tag});
    endtask

    task automatic exp_mon(input int c, input logic m, input string tag);
        sb.push_back('{cyc: c, is_mon: 1, p: 1'b0, r: 1'b0, l: 1'b0, m: m, tag: tag});
    endtask

    // monitor: pops items due this cycle and compares
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].cyc == cyc) begin
                    n_run++;
                    if (sb[i].is_mon) begin
                        if (mon !== sb[i].m) begin
                            n_fail++;
                            $display("FAIL %s cyc %0d: mon=%b expected %b", sb[i].tag, cyc, mon, sb[i].m);
                        end
                    end else if ({phi_p, phi_r, lock} !== {sb[i].p, sb[i].r, sb[i].l}) begin
                        n_fail++;
                        $display("FAIL %s cyc %0d: p/r/l=%b%b%b expected %b%b%b", sb[i].tag, cyc,
                                 phi_p, phi_r, lock, sb[i].p, sb[i].r, sb[i].l);
                    end
                    sb.delete(i);
                end
            end
        end
    end

    task automatic finish_run;
        done = 1;
        foreach (sb[i]) begin
            n_run++; n_fail++;
            $display("FAIL %s: item for cyc %0d never checked (actual none, expected check)", sb[i].tag, sb[i].cyc);
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        while (cyc < WATCHDOG && !done) @(negedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: cyc=%0d expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        int b;
        at(3);
        n_run++;   // R1 during reset
        if ({phi_p, phi_r, lock, mon} !== 4'b1010) begin
            n_fail++;
            $display("FAIL R1: p/r/l/m=%b%b%b%b expected 1010", phi_p, phi_r, lock, mon);
        end
        at(5); rst_n = 1;
        exp_pfd(8, 1, 0, 1, "R1 idle after release");
        exp_mon(8, 0, "R1 mon after release");

        // S1: pol=1, ref leads; falling and repeated edges; then div closes
        b = 12; at(b);
        ref_s = 1;
        exp_pfd(b + LAT - 1, 1, 0, 1, "R10 not before latency");
        exp_pfd(b + LAT, 0, 0, 0, "R3 ref leads direct");
        exp_mon(b + MLAT - 1, 0, "R9 mon lag");
        exp_mon(b + MLAT, 1, "R9 mon shows ref");
        exp_pfd(b + 2 + LAT + 1, 0, 0, 0, "R2 falling edge ignored");
        exp_pfd(b + 6 + LAT + 1, 0, 0, 0, "R2 repeated edge ignored");
        exp_pfd(b + 10 + LAT, 0, 1, 0, "R7 overlap cycle 1");
        exp_pfd(b + 10 + LAT + 1, 0, 1, 0, "R7 overlap cycle 2");
        exp_pfd(b + 10 + LAT + 2, 1, 0, 1, "R7 joint clear R8");
        at(b + 2);  ref_s = 0;
        at(b + 6);  ref_s = 1;
        at(b + 8);  ref_s = 0;
        at(b + 10); div_s = 1;
        at(b + 12); div_s = 0;

        // S2: pol=1, div leads
        b = 40; at(b);
        div_s = 1;
        exp_pfd(b + LAT, 1, 1, 0, "R4 div leads direct");
        exp_pfd(b + 5 + LAT, 0, 1, 0, "R7 overlap direct");
        exp_pfd(b + 5 + LAT + 2, 1, 0, 1, "R7 clear direct");
        at(b + 5);  ref_s = 1;
        at(b + 12); ref_s = 0; div_s = 0;

        // S3: pol=0, div leads
        b = 60; at(b);
        pol = 0; div_s = 1;
        exp_pfd(b + LAT, 0, 0, 0, "R5 div leads swapped");
        exp_mon(b + MLAT, 1, "R9 mon shows div");
        exp_pfd(b + 5 + LAT, 0, 1, 0, "R7 overlap swapped");
        exp_pfd(b + 5 + LAT + 2, 1, 0, 1, "R7 clear swapped");
        at(b + 5);  ref_s = 1;
        at(b + 12); ref_s = 0; div_s = 0;

        // S4: pol=0, ref leads
        b = 80; at(b);
        ref_s = 1;
        exp_pfd(b + LAT, 1, 1, 0, "R6 ref leads swapped");
        exp_pfd(b + 5 + LAT + 2, 1, 0, 1, "R7 clear after R6");
        at(b + 5);  div_s = 1;
        at(b + 12); ref_s = 0; div_s = 0;

        // S5: pol=1, coincident edges, then polarity flip on monitor
        b = 100; at(b);
        pol = 1; ref_s = 1; div_s = 1;
        exp_pfd(b + LAT, 0, 1, 0, "R7 coincident cycle 1");
        exp_pfd(b + LAT + 1, 0, 1, 0, "R7 coincident cycle 2");
        exp_pfd(b + LAT + 2, 1, 0, 1, "R7 coincident clear");
        exp_mon(b + 10, 1, "R9 mon before flip");
        exp_mon(b + 11, 0, "R9 mon after flip to div");
        exp_mon(b + 13, 1, "R9 mon after flip back to ref");
        at(b + 6);  div_s = 0;
        at(b + 10); pol = 0;
        at(b + 12); pol = 1;
        at(b + 14); ref_s = 0;

        at(130);
        finish_run();
    end

endmodule